// File: doc/BRIEF.md
# Parallel NOR Flash Read Sequencer

This block lets a host read a parallel NOR flash as if it were a plain random-access memory. The host gives a byte address and a width choice (one byte or one 16-bit word) through a valid/ready handshake. The sequencer then takes these steps:

- It drives the flash address pins and the byte/word organisation select.
- It holds chip enable and output enable low for a fixed, parameterised access window.
- It captures the data bus one cycle before output enable goes high again.
- It returns the result through a second valid/ready handshake.

Any address can be read in any order. No page or block sequencing is needed.

In byte organisation the device uses its top data pin as the lowest address bit. The sequencer therefore drives that pin with bit 0 of the byte address and returns only the low data lane. In word organisation the pin is an input and all sixteen lanes are returned. After reset the sequencer pulses the flash reset pin low for a parameterised number of cycles. It then waits until the synchronised ready/busy line reads high before it takes any request. It also refuses new requests while that line shows busy.

Top module: `nor_rd_seq`

## Requirements
- R1: After `rst_n` is released, `flash_rst_n` stays low for exactly `RST_CYC` falling-edge samples and then goes high. While it is low, `flash_ce_n` and `flash_oe_n` are high and `req_ready` is low.
- R2: After the reset pulse, `req_ready` stays low for as long as `flash_rdy` is low. Once `flash_rdy` is high, `req_ready` rises within `SYNC_STAGES`+1 cycles.
- R3: `req_ready` is high only when no access or response is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R4: During an access, `flash_addr` equals bits [ADDR_W-1:1] of the accepted byte address and does not change while `flash_oe_n` is low.
- R5: When `req_word`=1 is accepted, `flash_byte_n` is 1 and `flash_dq15_oe` is 0. When `req_word`=0 is accepted, `flash_byte_n` is 0, `flash_dq15_oe` is 1 and `flash_dq15_out` equals address bit 0.
- R6: For each access, `flash_ce_n` and `flash_oe_n` are low together for exactly `ACC_CYC`+1 cycles. The data bus is captured at the clock edge that ends the `ACC_CYC`-th low cycle, which is one cycle before `flash_oe_n` rises.
- R7: In word mode `rsp_data` equals `flash_dq_in[15:0]`. In byte mode it equals {8'h00, `flash_dq_in[7:0]`}.
- R8: `rsp_valid` rises in the cycle after `flash_oe_n` rises. It stays high with `rsp_data` unchanged until `rsp_ready` is seen, and `req_ready` stays low meanwhile.
- R9: Between two accesses, `flash_ce_n` and `flash_oe_n` are high for at least one cycle.
- R10: While the synchronised `flash_rdy` is low in the idle state, `req_valid` has no effect: `req_ready` stays low and `flash_oe_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ADDR_W | Byte address of the read |
| req_word | input | 1 | 1 = 16-bit word read, 0 = byte read |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Host takes the read data |
| rsp_data | output | 16 | Read data; upper byte is zero for a byte read |
| flash_addr | output | ADDR_W-1 | Flash address pins (word-granular) |
| flash_dq_in | input | 16 | Flash data bus as seen by the host |
| flash_dq15_out | output | 1 | Lowest byte-address bit driven onto the top data pin in byte mode |
| flash_dq15_oe | output | 1 | Drive enable for the top data pin |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_byte_n | output | 1 | Organisation select: 1 = x16, 0 = x8 |
| flash_rst_n | output | 1 | Flash reset, active low |
| flash_rdy | input | 1 | Ready/busy from the flash, high = ready (pulled up on the board) |

## Verification
The assertions assume that `rst_n` is asserted once at power-up. They also assume that `flash_rdy` is a level the synchroniser may see one or two cycles late, so no property ties `req_ready` to a particular sample of that pin. The response-stability and pin-coherence properties depend only on the handshake inputs.

The stimulus changes every input on the falling clock edge. It lowers `flash_rdy` only while the sequencer is idle or still waiting after reset. It never needs the flash model to drive valid data before the output-enable window has reached its capture point, so any early sample shows up as a marker word.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;

   typedef enum logic [2:0] {
      SQ_PULSE = 3'd0,
      SQ_SETTLE = 3'd1,
      SQ_IDLE  = 3'd2,
      SQ_READ  = 3'd3,
      SQ_HAND  = 3'd4
   } sq_state_t;

   function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m < 2) ? 1 : $clog2(m + 1);
   endfunction

endpackage

// File: rtl/nor_rd_sync.sv
module nor_rd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("nor_rd_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/nor_rd_timer.sv
module nor_rd_timer #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/nor_rd_lane.sv
module nor_rd_lane #(
   parameter int unsigned ADDR_W = 21,
   parameter bit          X16_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              word,
   input  logic [15:0]       dq_in,
   output logic [ADDR_W-2:0] pin_addr,
   output logic              pin_byte_n,
   output logic              pin_dq15,
   output logic              lane_byte,
   output logic [15:0]       data
);
   assign pin_addr = addr[ADDR_W-1:1];
   assign pin_dq15 = addr[0];

   generate
      if (X16_EN) begin : g_dual
         assign pin_byte_n = word;
         assign lane_byte  = ~word;
         assign data       = word ? dq_in : {8'h00, dq_in[7:0]};
      end else begin : g_byte_only
         logic unused_hi;
         assign unused_hi  = ^{word, dq_in[15:8]};
         assign pin_byte_n = 1'b0;
         assign lane_byte  = 1'b1;
         assign data       = {8'h00, dq_in[7:0]};
      end
   endgenerate
endmodule

// File: rtl/nor_rd_seq.sv
module nor_rd_seq #(
   parameter int unsigned ADDR_W      = 21,
   parameter int unsigned ACC_CYC     = 4,
   parameter int unsigned RST_CYC     = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          X16_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_word,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [15:0]       rsp_data,
   output logic [ADDR_W-2:0] flash_addr,
   input  logic [15:0]       flash_dq_in,
   output logic              flash_dq15_out,
   output logic              flash_dq15_oe,
   output logic              flash_ce_n,
   output logic              flash_oe_n,
   output logic              flash_byte_n,
   output logic              flash_rst_n,
   input  logic              flash_rdy
);
   import nor_rd_pkg::*;

   localparam int unsigned CW = cnt_bits(ACC_CYC, RST_CYC);
   localparam logic [CW-1:0] CAP_AT = CW'(ACC_CYC - 1);
   localparam logic [CW-1:0] END_AT = CW'(ACC_CYC);
   localparam logic [CW-1:0] RST_AT = CW'(RST_CYC);

   generate
      if (ADDR_W < 2)  begin : g_chk_aw  $error("nor_rd_seq: ADDR_W must be >= 2"); end
      if (ACC_CYC < 1) begin : g_chk_acc $error("nor_rd_seq: ACC_CYC must be >= 1"); end
      if (RST_CYC < 1) begin : g_chk_rst $error("nor_rd_seq: RST_CYC must be >= 1"); end
   endgenerate

   sq_state_t         st;
   logic [CW-1:0]     cnt;
   logic              rdy_s;
   logic [ADDR_W-1:0] addr_q;
   logic              word_q;
   logic [15:0]       data_q;
   logic [15:0]       lane_data;
   logic              lane_byte;

   nor_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(flash_rdy), .dout(rdy_s)
   );

   nor_rd_timer #(.W(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(st == SQ_IDLE), .cnt(cnt)
   );

   nor_rd_lane #(.ADDR_W(ADDR_W), .X16_EN(X16_EN)) u_lane (
      .addr(addr_q), .word(word_q), .dq_in(flash_dq_in),
      .pin_addr(flash_addr), .pin_byte_n(flash_byte_n), .pin_dq15(flash_dq15_out),
      .lane_byte(lane_byte), .data(lane_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_PULSE;
         addr_q <= '0;
         word_q <= X16_EN;
         data_q <= '0;
      end else begin
         case (st)
            SQ_PULSE:  if (cnt == RST_AT) st <= SQ_SETTLE;
            SQ_SETTLE: if (rdy_s) st <= SQ_IDLE;
            SQ_IDLE: begin
               if (req_valid && rdy_s) begin
                  st     <= SQ_READ;
                  addr_q <= req_addr;
                  word_q <= req_word;
               end
            end
            SQ_READ: begin
               if (cnt == CAP_AT) data_q <= lane_data;
               if (cnt == END_AT) st <= SQ_HAND;
            end
            SQ_HAND:   if (rsp_ready) st <= SQ_IDLE;
            default:   st <= SQ_PULSE;
         endcase
      end
   end

   assign flash_rst_n   = (st != SQ_PULSE);
   assign flash_ce_n    = (st != SQ_READ);
   assign flash_oe_n    = (st != SQ_READ);
   assign flash_dq15_oe = (st == SQ_READ) && lane_byte;
   assign req_ready     = (st == SQ_IDLE) && rdy_s;
   assign rsp_valid     = (st == SQ_HAND);
   assign rsp_data      = data_q;
endmodule

// File: rtl/nor_rd_seq_chk.sv
module nor_rd_seq_chk #(
   parameter int unsigned ADDR_W = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [15:0]       rsp_data,
   input logic [ADDR_W-2:0] flash_addr,
   input logic              flash_dq15_oe,
   input logic              flash_ce_n,
   input logic              flash_oe_n,
   input logic              flash_byte_n,
   input logic              flash_rst_n
);
   // R1
   pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_rst_n |-> (flash_oe_n && flash_ce_n && !req_ready));

   // R6
   oe_with_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_oe_n |-> !flash_ce_n);

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_oe_n && $past(!flash_oe_n)) |-> $stable(flash_addr));

   // R5
   dq15_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_oe_n |-> (flash_dq15_oe == !flash_byte_n));

   // R8
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

   // R8
   rsp_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!req_ready && flash_oe_n));

   // R9
   gap_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flash_oe_n) |=> flash_oe_n);

   // R3
   ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (flash_ce_n && !rsp_valid));
endmodule

bind nor_rd_seq nor_rd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .rsp_ready(rsp_ready), .rsp_data(rsp_data), .flash_addr(flash_addr),
   .flash_dq15_oe(flash_dq15_oe), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
   .flash_byte_n(flash_byte_n), .flash_rst_n(flash_rst_n)
);

// File: tb/sim_nor_rd_seq.sv
`timescale 1ns/1ps
module sim_nor_rd_seq;
   localparam int unsigned AW   = 8;
   localparam int unsigned ACC  = 4;
   localparam int unsigned RSTC = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_word = 1'b0, rsp_ready = 1'b0, flash_rdy = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic req_ready, rsp_valid, flash_dq15_out, flash_dq15_oe;
   logic flash_ce_n, flash_oe_n, flash_byte_n, flash_rst_n;
   logic [15:0] rsp_data, flash_dq_in;
   logic [AW-2:0] flash_addr;

   int total = 0, bad = 0, cyc = 0, lowcnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   nor_rd_seq #(.ADDR_W(AW), .ACC_CYC(ACC), .RST_CYC(RSTC), .SYNC_STAGES(2), .X16_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_word(req_word), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_data(rsp_data), .flash_addr(flash_addr),
      .flash_dq_in(flash_dq_in), .flash_dq15_out(flash_dq15_out),
      .flash_dq15_oe(flash_dq15_oe), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
      .flash_byte_n(flash_byte_n), .flash_rst_n(flash_rst_n), .flash_rdy(flash_rdy)
   );

   function automatic logic [15:0] wdat(input int w);
      int v;
      v = (w * 40503 + 4660) ^ (w << 9);
      return v[15:0];
   endfunction

   function automatic logic [15:0] exp_rd(input int a, input bit word);
      logic [15:0] w;
      w = wdat(a >> 1);
      if (word) return w;
      return (a % 2 == 1) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
   endfunction

   // flash model: valid data only once output enable has been low long enough
   always @(posedge clk) lowcnt <= (!flash_oe_n) ? lowcnt + 1 : 0;

   always_comb begin
      logic [15:0] w;
      w = wdat(int'(flash_addr));
      if (flash_ce_n || flash_oe_n || lowcnt < ACC - 1)
         flash_dq_in = 16'hBAD1;
      else if (flash_byte_n)
         flash_dq_in = w;
      else
         flash_dq_in = {flash_dq15_out, 7'h2A, flash_dq15_out ? w[15:8] : w[7:0]};
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(1'b0, "watchdog", cyc, 150000);
         finish_run();
      end
   end

   task automatic do_read(input int a, input bit word, input int stall);
      int n, oe_low;
      bit addr_ok, mode_ok;
      logic [15:0] held;
      req_addr  = AW'(a);
      req_word  = word;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      oe_low = 0; addr_ok = 1'b1; mode_ok = 1'b1; n = 0;
      while (!rsp_valid && n < 50) begin
         if (!flash_oe_n) begin
            oe_low++;
            if (int'(flash_addr) != (a >> 1) || flash_ce_n) addr_ok = 1'b0;
            if (word && (flash_byte_n != 1'b1 || flash_dq15_oe != 1'b0)) mode_ok = 1'b0;
            if (!word && (flash_byte_n != 1'b0 || flash_dq15_oe != 1'b1 ||
                          flash_dq15_out != a[0])) mode_ok = 1'b0;
         end
         n++;
         @(negedge clk);
      end
      // R4: address pins during the window
      chk(addr_ok, "R4 addr pins", a >> 1, a >> 1);
      // R5: organisation select and top data pin
      chk(mode_ok, "R5 mode pins", int'(word), int'(word));
      // R6: window length
      chk(oe_low == ACC + 1, "R6 oe window", oe_low, ACC + 1);
      // R8: enables released when response shows
      chk(flash_oe_n && flash_ce_n, "R8 enables off at rsp", int'(flash_oe_n), 1);
      // R7: data lanes (also depends on R6 capture point)
      chk(rsp_data == exp_rd(a, word), "R7 data", int'(rsp_data), int'(exp_rd(a, word)));
      held = rsp_data;
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         // R8: stalled response holds
         chk(rsp_valid && rsp_data == held && !req_ready, "R8 stall hold",
             int'(rsp_data), int'(held));
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      // R9: gap before next access
      chk(!rsp_valid && flash_oe_n && flash_ce_n, "R9 gap", int'(flash_oe_n), 1);
   endtask

   initial begin
      int lows;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!flash_rst_n && flash_oe_n && flash_ce_n && !req_ready && !rsp_valid,
          "R1 reset state", int'(flash_rst_n), 0);
      rst_n = 1'b1;
      lows = 0;
      for (int i = 0; i < RSTC + 4; i++) begin
         @(negedge clk);
         if (!flash_rst_n) begin
            lows++;
            // R1: no access during pulse
            if (!flash_oe_n || req_ready) chk(1'b0, "R1 quiet pulse", int'(flash_oe_n), 1);
         end
      end
      // R1: pulse width
      chk(lows == RSTC, "R1 pulse width", lows, RSTC);
      req_valid = 1'b1;
      for (int i = 0; i < 12; i++) @(negedge clk);
      // R2: busy after reset keeps requests off
      chk(!req_ready && flash_oe_n, "R2 wait ready", int'(req_ready), 0);
      req_valid = 1'b0;
      flash_rdy = 1'b1;
      repeat (3) @(negedge clk);
      // R2: ready after sync
      chk(req_ready, "R2 ready seen", int'(req_ready), 1);
      // R3: first read right away
      do_read(8'h00, 1'b1, 0);
      chk(req_ready, "R3 idle ready", int'(req_ready), 1);

      // R10: busy while idle
      flash_rdy = 1'b0;
      repeat (3) @(negedge clk);
      req_addr = 8'h11; req_word = 1'b0; req_valid = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (req_ready || !flash_oe_n) chk(1'b0, "R10 busy ignore", int'(flash_oe_n), 1);
      end
      chk(!req_ready && flash_oe_n, "R10 busy ignore", int'(req_ready), 0);
      req_valid = 1'b0;
      flash_rdy = 1'b1;
      repeat (3) @(negedge clk);

      // sweep every byte address in both organisations
      for (int a = 0; a < (1 << AW); a++) begin
         do_read(a, 1'b1, a % 4);
         do_read(a, 1'b0, (a + 1) % 3);
      end
      finish_run();
   end
endmodule